// File: doc/BRIEF.md
# Register Context Loader

This block loads batches of register settings for a display pipeline from memory. Software prepares up to three lists of entries in memory and programs their base addresses and entry counts. It then sets a start bit. The engine walks the lists through a simple read-request master port and turns each entry into one write on a local register-write port.

Each entry is 64 bits wide. The low word is the data value and the high word is the target register offset. The single-buffered area holds a high-priority list followed directly by a low-priority list. A separate double-buffered list has its own base address.

A control/status word holds the start bit, an arbitration-select bit, per-event interrupt enables and sticky event flags. The interrupt output is the OR of every flag that has its enable set. When a fetch returns an error, the load is aborted. In the bus-error case the failing address is kept for software.

Top module: `ctx_reg_loader`

## Requirements
- R1: Each fetched entry arrives on `rd_data`, with the value in bits 31:0 and the register offset in bits 63:32. It produces exactly one write with `wr_data` equal to the value and `wr_addr` equal to the offset.
- R2: Lists are processed in a fixed order: high-priority first, then low-priority, then double-buffer. Entry i of a list is fetched from its base plus 8·i. The low-priority base is the single-buffer base plus 8 times the high-priority count.
- R3: A list whose count is zero is skipped. If all three counts are zero, a start request leaves control bit 0 reading 0 on the next cycle and issues no fetch.
- R4: Handshakes on both ports:
  - `wr_valid`, `wr_addr` and `wr_data` hold steady until `wr_ready`.
  - No fetch is issued while a write is pending.
  - `rd_req` and `rd_addr` hold until `rd_valid`.
- R5: Writing control bit 0 as 1 while idle starts a load. Bit 0 reads 1 while loading and clears itself after the last non-empty list. A finished list raises its completion flag: bit 17 for double-buffer, bit 18 for high-priority, bit 19 for low-priority.
- R6: `rd_err` on a fetch response has three effects:
  - It sets flag bit 16.
  - It clears control bit 0.
  - It stops the load, so no write is issued for that entry or any later one.
- R7: `bus_err` on a fetch response aborts the load in the same way and sets flag bit 22. The fetch address is captured in the read-only word at offset 0x20.
- R8: Flags in bits 22:16 are sticky and are cleared by writing 1 to them at offset 0x0. If a hardware set and a clear of the same flag fall in one cycle, the flag stays set.
- R9: A start request (bit 0 written as 1) while a load is running sets flag bit 20. It has no other effect on the running load.
- R10: Flag bit 21 is set by a load that starts while `disp_active` is high and at least one single-buffer count is non-zero.
- R11: `irq` is high exactly when some flag bit 16+k is set and its enable bit 2+k is set, for k in 0..6.
- R12: The following locations read back what was written:
  - 0x10: double-buffer base.
  - 0x14: double-buffer count, bits 15:0.
  - 0x18: single-buffer base.
  - 0x1C: high-priority count in bits 15:0 and low-priority count in bits 31:16.
  - 0x0: enable bits 8:1, including the arbitration-select bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, combinational on `cfg_addr` |
| disp_active | input | 1 | Display is scanning out active video |
| rd_req | output | 1 | Fetch request, held until `rd_valid` |
| rd_addr | output | AW | Fetch byte address |
| rd_valid | input | 1 | Fetch response valid |
| rd_data | input | 2*DW | Entry: offset in the upper half, value in the lower half |
| rd_err | input | 1 | Fetch response carries a read error |
| bus_err | input | 1 | Fetch response carries a bus error |
| wr_valid | output | 1 | Register write valid |
| wr_addr | output | DW | Register write offset |
| wr_data | output | DW | Register write value |
| wr_ready | input | 1 | Register write accepted |
| irq | output | 1 | Interrupt request |

## Verification
A start request that arrives while a load is running can land in the same cycle as a write-one-to-clear of the flag that this request sets. The bench provokes this with a single control write issued mid-load that carries both bit 0 and bit 20. It expects bit 20 to survive the write and to still read set once the load ends. The bench also throttles `wr_ready` with a pseudo-random pattern, so that completions and list changes fall on stalled and unstalled cycles. Every accepted write is compared against a queue of entries built from the programmed lists.

// File: rtl/ctx_reg_loader.sv
`timescale 1ns/1ps
module ctx_reg_loader #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [5:0]      cfg_addr,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  input  logic            disp_active,
  output logic            rd_req,
  output logic [AW-1:0]   rd_addr,
  input  logic            rd_valid,
  input  logic [2*DW-1:0] rd_data,
  input  logic            rd_err,
  input  logic            bus_err,
  output logic            wr_valid,
  output logic [DW-1:0]   wr_addr,
  output logic [DW-1:0]   wr_data,
  input  logic            wr_ready,
  output logic            irq
);
  localparam int NFLG = 7;
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WRITE} st_t;

  st_t            state;
  logic           busy;
  logic [7:0]     en;
  logic [NFLG-1:0] flg;
  logic [AW-1:0]  db_base, sb_base, err_addr, cur_addr;
  logic [CW-1:0]  db_cnt, hp_cnt, lp_cnt, left;
  logic [1:0]     lst;
  logic [DW-1:0]  val_q, off_q;

  logic [1:0]     first_l, nxt_l;
  logic           first_ok, nxt_ok;
  logic [AW-1:0]  lp_base;
  logic [NFLG-1:0] hw_set, sw_clr;

  wire ctrl_wr    = cfg_wr && cfg_addr == 6'h00;
  wire req_start  = ctrl_wr && cfg_wdata[0];
  wire start      = req_start && !busy;
  wire fetch_done = state == S_FETCH && rd_valid;
  wire fetch_bad  = fetch_done && (rd_err || bus_err);
  wire wr_done    = state == S_WRITE && wr_ready;
  wire last       = left == CW'(1);
  wire list_end   = wr_done && last;

  assign lp_base = sb_base + (AW'(hp_cnt) << 3);

  always_comb begin
    first_ok = 1'b1;
    first_l  = 2'd0;
    if (hp_cnt != '0)      first_l = 2'd0;
    else if (lp_cnt != '0) first_l = 2'd1;
    else if (db_cnt != '0) first_l = 2'd2;
    else                   first_ok = 1'b0;
    nxt_ok = 1'b1;
    nxt_l  = 2'd2;
    if (lst == 2'd0 && lp_cnt != '0)      nxt_l = 2'd1;
    else if (lst != 2'd2 && db_cnt != '0) nxt_l = 2'd2;
    else                                  nxt_ok = 1'b0;
  end

  always_comb begin
    hw_set    = '0;
    hw_set[0] = fetch_done && rd_err;
    hw_set[1] = list_end && lst == 2'd2;
    hw_set[2] = list_end && lst == 2'd0;
    hw_set[3] = list_end && lst == 2'd1;
    hw_set[4] = req_start && busy;
    hw_set[5] = start && disp_active && (hp_cnt != '0 || lp_cnt != '0);
    hw_set[6] = fetch_done && bus_err;
    sw_clr    = ctrl_wr ? cfg_wdata[16 +: NFLG] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= '0; flg <= '0;
      db_base <= '0; sb_base <= '0; db_cnt <= '0; hp_cnt <= '0; lp_cnt <= '0;
      err_addr <= '0;
    end else begin
      flg <= (flg & ~sw_clr) | hw_set;
      if (ctrl_wr) en <= cfg_wdata[8:1];
      if (cfg_wr) begin
        case (cfg_addr)
          6'h10: db_base <= cfg_wdata[AW-1:0];
          6'h14: db_cnt  <= cfg_wdata[CW-1:0];
          6'h18: sb_base <= cfg_wdata[AW-1:0];
          6'h1C: begin hp_cnt <= cfg_wdata[CW-1:0]; lp_cnt <= cfg_wdata[16 +: CW]; end
          default: ;
        endcase
      end
      if (fetch_done && bus_err) err_addr <= cur_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; busy <= 1'b0; lst <= '0; left <= '0;
      cur_addr <= '0; val_q <= '0; off_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (start && first_ok) begin
          busy  <= 1'b1;
          state <= S_FETCH;
          lst   <= first_l;
          case (first_l)
            2'd0:    begin cur_addr <= sb_base; left <= hp_cnt; end
            2'd1:    begin cur_addr <= lp_base; left <= lp_cnt; end
            default: begin cur_addr <= db_base; left <= db_cnt; end
          endcase
        end
        S_FETCH: if (fetch_bad) begin
          busy  <= 1'b0;
          state <= S_IDLE;
        end else if (fetch_done) begin
          val_q <= rd_data[DW-1:0];
          off_q <= rd_data[2*DW-1:DW];
          state <= S_WRITE;
        end
        S_WRITE: if (wr_done) begin
          if (!last) begin
            left     <= left - CW'(1);
            cur_addr <= cur_addr + AW'(8);
            state    <= S_FETCH;
          end else if (nxt_ok) begin
            lst   <= nxt_l;
            state <= S_FETCH;
            if (nxt_l == 2'd1) begin cur_addr <= lp_base; left <= lp_cnt; end
            else               begin cur_addr <= db_base; left <= db_cnt; end
          end else begin
            busy  <= 1'b0;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign rd_req   = state == S_FETCH;
  assign rd_addr  = cur_addr;
  assign wr_valid = state == S_WRITE;
  assign wr_addr  = off_q;
  assign wr_data  = val_q;
  assign irq      = |(flg & en[7:1]);

  always_comb begin
    case (cfg_addr)
      6'h00:   cfg_rdata = {9'b0, flg, 7'b0, en, busy};
      6'h10:   cfg_rdata = 32'(db_base);
      6'h14:   cfg_rdata = 32'(db_cnt);
      6'h18:   cfg_rdata = 32'(sb_base);
      6'h1C:   cfg_rdata = {16'(lp_cnt), 16'(hp_cnt)};
      6'h20:   cfg_rdata = 32'(err_addr);
      default: cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ctx_reg_loader_chk.sv
`timescale 1ns/1ps
module ctx_reg_loader_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_valid,
  input logic          rd_err,
  input logic          bus_err,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [DW-1:0] wr_addr,
  input logic [DW-1:0] wr_data
);
  p_wr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_valid |=> rd_req && $stable(rd_addr));

  p_no_fetch_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !rd_req);

  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_valid && rd_err |=> !wr_valid && !rd_req && !busy);

  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_valid && bus_err |=> !wr_valid && !rd_req && !busy);

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req && !wr_valid);
endmodule

bind ctx_reg_loader ctx_reg_loader_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr),
  .rd_valid(rd_valid), .rd_err(rd_err), .bus_err(bus_err), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data));

// File: tb/tb_ctx_reg_loader.sv
`timescale 1ns/1ps
module tb_ctx_reg_loader;
  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0;
  logic [5:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic disp_active = 0;
  logic rd_req, rd_valid = 0, rd_err = 0, bus_err = 0;
  logic [31:0] rd_addr;
  logic [63:0] rd_data = 0;
  logic wr_valid, wr_ready = 0, irq;
  logic [31:0] wr_addr, wr_data;

  ctx_reg_loader dut (.*);

  always #2 clk = ~clk;

  logic [63:0] mem [int unsigned];
  logic [63:0] exp_q [$];
  logic [31:0] rerr_at = 32'hFFFF_FFFF, berr_at = 32'hFFFF_FFFF;
  logic [7:0]  lfsr = 8'hA5;
  int lat = 0, checks = 0, fails = 0, nwr = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder and write monitor (reference model of the accepted writes)
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    wr_ready = lfsr[0] | lfsr[2];
    if (rst_n && wr_valid && wr_ready) begin
      nwr++;
      if (exp_q.size() == 0) chk("R1 unexpected write", wr_addr, 32'hDEAD_DEAD);
      else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        chk("R1/R2 write offset", wr_addr, e[63:32]);
        chk("R1/R2 write value", wr_data, e[31:0]);
      end
    end
    if (rd_valid) begin
      rd_valid = 0; rd_err = 0; bus_err = 0;
    end else if (rst_n && rd_req) begin
      lat++;
      if (lat >= 2) begin
        lat = 0;
        rd_valid = 1;
        rd_data = mem.exists(rd_addr) ? mem[rd_addr] : 64'h0;
        rd_err = (rd_addr == rerr_at);
        bus_err = (rd_addr == berr_at);
      end
    end
  end

  task automatic cw(logic [5:0] a, logic [31:0] d);
    @(negedge clk); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic cr(logic [5:0] a, output logic [31:0] v);
    @(negedge clk); cfg_addr = a; #1 v = cfg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    do cr(6'h00, v); while (v[0] === 1'b1);
  endtask

  task automatic put_list(logic [31:0] base, int n, logic [31:0] tag, int nexp);
    for (int i = 0; i < n; i++) begin
      logic [31:0] val, off;
      val = tag ^ (32'h0101_0101 * (i + 1));
      off = {16'h0, tag[15:0]} + 32'(i * 4);
      mem[base + 32'(8 * i)] = {off, val};
      if (i < nexp) exp_q.push_back({off, val});
    end
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    cr(6'h00, v); chk("R5 reset ctrl", v, 32'h0);
    chk("R11 reset irq", {31'b0, irq}, 32'h0);
    chk("R4 reset no request", {30'b0, rd_req, wr_valid}, 32'h0);

    // high-priority only; irq enable on bit4
    put_list(32'h1000, 3, 32'hA000_0100, 3);
    cw(6'h18, 32'h1000); cw(6'h1C, 32'h0000_0003); cw(6'h14, 32'h0);
    cw(6'h00, 32'h0000_0011);
    cr(6'h00, v); chk("R5 busy while loading", {31'b0, v[0]}, 32'h1);
    wait_idle();
    chk("R5 all written", exp_q.size(), 0);
    cr(6'h00, v); chk("R5 hp complete flag bit18", {25'b0, v[22:16]}, 32'h04);
    chk("R11 irq on enabled hp flag", {31'b0, irq}, 32'h1);

    // clear flags
    cw(6'h00, 32'h007F_0010);
    cr(6'h00, v); chk("R8 flags cleared", {25'b0, v[22:16]}, 32'h0);
    chk("R11 irq dropped", {31'b0, irq}, 32'h0);

    // three lists, order HP, LP, DB; same-cycle start-while-busy and its clear
    put_list(32'h2000, 2, 32'hB000_0200, 2);
    put_list(32'h2010, 3, 32'hC000_0300, 3);
    put_list(32'h8000, 2, 32'hD000_0400, 2);
    cw(6'h18, 32'h2000); cw(6'h1C, 32'h0003_0002);
    cw(6'h10, 32'h8000); cw(6'h14, 32'h2);
    cw(6'h00, 32'h0000_0039);
    cw(6'h00, 32'h0010_0039);
    wait_idle();
    chk("R2 ordered lists consumed", exp_q.size(), 0);
    cr(6'h00, v); chk("R5 R8 R9 flags after three lists", {25'b0, v[22:16]}, 32'h1E);
    chk("R9 enables kept", {24'b0, v[8:1]}, 32'h1C);

    // all counts zero
    cw(6'h00, 32'h007F_0000);
    cw(6'h1C, 32'h0); cw(6'h14, 32'h0);
    nwr = 0;
    cw(6'h00, 32'h0000_0001);
    cr(6'h00, v); chk("R3 empty start stays idle", v, 32'h0);
    repeat (10) @(negedge clk);
    chk("R3 no writes on empty lists", nwr, 0);

    // read error on second double-buffer entry
    put_list(32'h3000, 3, 32'hE000_0500, 1);
    rerr_at = 32'h3008;
    cw(6'h10, 32'h3000); cw(6'h14, 32'h3);
    cw(6'h00, 32'h0000_0005);
    wait_idle();
    repeat (10) @(negedge clk);
    chk("R6 writes stop at error", exp_q.size(), 0);
    cr(6'h00, v); chk("R6 read error flag bit16", {25'b0, v[22:16]}, 32'h01);
    chk("R6 irq on read error", {31'b0, irq}, 32'h1);
    rerr_at = 32'hFFFF_FFFF;

    // bus error on second high-priority entry
    cw(6'h00, 32'h007F_0000);
    cw(6'h14, 32'h0);
    put_list(32'h4000, 2, 32'hF000_0600, 1);
    berr_at = 32'h4008;
    cw(6'h18, 32'h4000); cw(6'h1C, 32'h0000_0002);
    cw(6'h00, 32'h0000_0101);
    wait_idle();
    repeat (10) @(negedge clk);
    chk("R7 writes stop at bus error", exp_q.size(), 0);
    cr(6'h00, v); chk("R7 bus error flag bit22", {25'b0, v[22:16]}, 32'h40);
    cr(6'h20, v); chk("R7 captured address", v, 32'h4008);
    chk("R11 irq on bus error", {31'b0, irq}, 32'h1);
    berr_at = 32'hFFFF_FFFF;

    // display active at start
    cw(6'h00, 32'h007F_0000);
    put_list(32'h5000, 1, 32'h1234_0700, 1);
    disp_active = 1;
    cw(6'h18, 32'h5000); cw(6'h1C, 32'h0000_0001);
    cw(6'h00, 32'h0000_0001);
    disp_active = 0;
    wait_idle();
    cr(6'h00, v); chk("R10 display-active flag bit21", {25'b0, v[22:16]}, 32'h24);
    chk("R11 irq low without enables", {31'b0, irq}, 32'h0);
    cw(6'h00, 32'h0000_0080);
    chk("R11 irq follows enable bit7", {31'b0, irq}, 32'h1);

    // readback
    cw(6'h00, 32'h0000_0002);
    cr(6'h00, v); chk("R12 arbitration select bit1", v & 32'h0000_01FF, 32'h2);
    cw(6'h10, 32'hCAFE_0008); cr(6'h10, v); chk("R12 db base", v, 32'hCAFE_0008);
    cw(6'h14, 32'h0000_BEEF); cr(6'h14, v); chk("R12 db count", v, 32'h0000_BEEF);
    cw(6'h18, 32'h0BAD_F000); cr(6'h18, v); chk("R12 sb base", v, 32'h0BAD_F000);
    cw(6'h1C, 32'h1357_2468); cr(6'h1C, v); chk("R12 sb counts", v, 32'h1357_2468);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule